// File: doc/BRIEF.md
# Routed vectored interrupt controller

This block gathers 256 edge-triggered interrupt vectors for a group of four cores and turns them into per-core interrupt lines. A rising edge on a vector input latches a pending bit. The pending bit stays set until software writes a one to it. A pending vector reaches the outputs only when four things hold: its enable bit is set, the global enable is on, its route entry names this node, and its route entry names at least one core.

Each vector has a route byte. The byte carries a core bitmap in its low nibble and a target node number in its high nibble. Each group of 32 vectors has a line-select byte that chooses which of the eight lines per core the group drives. A per-vector single-target bit narrows a multi-core route to its lowest-numbered core. A node-map area is stored and read back only. Software reaches all of this through one 32-bit word port at fixed byte offsets. Reads are combinational from the stored state.

Top module: `rvic_top`

## Requirements
- R1: After reset, every table, the pending array and the global enable read zero, and `irq_o` is all zero.
- R2: Full 32-bit words written to the node map, line select, enable, single-target and route areas read back unchanged at the same offset.
- R3: A vector's pending bit sets on the first clock edge at which its input is high after being low. The enable bit has no influence on this latching. A level held high does not set the bit again once software has cleared it.
- R4: Pending bits for vectors 32h to 32h+31 read as the 32-bit half at 0x1800+4h, with vector n at bit n%32; 64-bit word w is the pair of halves 2w and 2w+1. Writing a half clears exactly the bits written as one.
- R5: Vector v is enabled by bit v%32 of the word at 0x1600+4*(v/32). A zero bit keeps the vector off the outputs, and the pending bit still latches. The vector drives its line once it is enabled.
- R6: The route byte of vector v is byte v%4 (bits 8*(v%4) up) of the word at 0x1C00+4*(v/4). Bits 3:0 are the core bitmap and bits 7:4 the node number. The vector drives nothing unless the node number equals `node_id_i`.
- R7: The line-select byte of group g=v/32 is byte g%4 of the word at 0x14C0+4*(g/4). Output bit c*8+k of `irq_o` is the OR over all qualified pending vectors whose core bitmap has bit c and whose group byte has bit k.
- R8: Single-target bits share the enable layout at base 0x1680. When the bit is set, only the lowest-numbered core in the bitmap receives the vector.
- R9: Bit 0 of the word at 0x0400 is the global enable. While it is zero, `irq_o` is zero and pending bits still latch.
- R10: The node map words at 0x14A0+4i (i from 0 to 7) have no effect on `irq_o`.
- R11: Misaligned addresses and addresses outside every area read zero.
- R12: When a rising edge and a clearing write hit the same vector in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| node_id_i | input | 4 | Node number this group answers to |
| vec_i | input | 256 | Interrupt vector inputs, edge-sensitive |
| reg_we_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 16 | Byte address of the 32-bit word accessed |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 32 | Per-core lines, core c line k at bit c*8+k |

## Verification
A register write, and a rising vector edge, both change state at the first clock edge after they are driven. Because `irq_o` and `reg_rdata_o` are combinational from that state, the new value of each is visible within the same cycle, straight after that edge. The bench drives every stimulus at a falling edge and reads results at the next falling edge. Each result is therefore sampled one full edge after its cause, and half a period away from any edge. The R12 collision places the rising input and the clearing write in the same falling-edge window, so both meet at the same clock edge.

// File: rtl/rvic_pkg.sv
package rvic_pkg;
    localparam logic [15:0] OFS_MISC    = 16'h0400;
    localparam logic [15:0] OFS_NODEMAP = 16'h14A0;
    localparam logic [15:0] OFS_IPMAP   = 16'h14C0;
    localparam logic [15:0] OFS_ENABLE  = 16'h1600;
    localparam logic [15:0] OFS_BOUNCE  = 16'h1680;
    localparam logic [15:0] OFS_STATUS  = 16'h1800;
    localparam logic [15:0] OFS_ROUTE   = 16'h1C00;
    localparam int          LINES       = 8;

    typedef enum logic [2:0] {
        RG_NONE, RG_MISC, RG_NMAP, RG_IPMAP, RG_ENABLE, RG_BOUNCE, RG_STATUS, RG_ROUTE
    } region_e;

    function automatic logic in_rng(input logic [15:0] a, input logic [15:0] base,
                                    input logic [15:0] nbytes);
        return (a - base) < nbytes;
    endfunction
endpackage

// File: rtl/rvic_cfg.sv
module rvic_cfg
    import rvic_pkg::*;
#(
    parameter int NVEC = 256,
    parameter int IW   = 6
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                we_i,
    input  region_e             rg_i,
    input  logic [IW-1:0]       widx_i,
    input  logic [31:0]         wdata_i,
    output logic [NVEC-1:0]     en_o,
    output logic [NVEC-1:0]     bnc_o,
    output logic [NVEC*8-1:0]   route_o,
    output logic [NVEC/4-1:0]   ipm_o,
    output logic                gen_o,
    output logic [31:0]         rdata_o
);
    localparam int NGRP = NVEC / 32;

    logic [NVEC-1:0]   en_q, bnc_q;
    logic [NVEC*8-1:0] route_q;
    logic [NGRP*8-1:0] ipm_q;
    logic [NGRP*32-1:0] nmap_q;
    logic              gen_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q    <= '0;
            bnc_q   <= '0;
            route_q <= '0;
            ipm_q   <= '0;
            nmap_q  <= '0;
            gen_q   <= 1'b0;
        end else if (we_i) begin
            unique case (rg_i)
                RG_MISC:   gen_q                     <= wdata_i[0];
                RG_NMAP:   nmap_q[widx_i*32 +: 32]   <= wdata_i;
                RG_IPMAP:  ipm_q[widx_i*32 +: 32]    <= wdata_i;
                RG_ENABLE: en_q[widx_i*32 +: 32]     <= wdata_i;
                RG_BOUNCE: bnc_q[widx_i*32 +: 32]    <= wdata_i;
                RG_ROUTE:  route_q[widx_i*32 +: 32]  <= wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rg_i)
            RG_MISC:   rdata_o = {31'b0, gen_q};
            RG_NMAP:   rdata_o = nmap_q[widx_i*32 +: 32];
            RG_IPMAP:  rdata_o = ipm_q[widx_i*32 +: 32];
            RG_ENABLE: rdata_o = en_q[widx_i*32 +: 32];
            RG_BOUNCE: rdata_o = bnc_q[widx_i*32 +: 32];
            RG_ROUTE:  rdata_o = route_q[widx_i*32 +: 32];
            default:   rdata_o = '0;
        endcase
    end

    assign en_o    = en_q;
    assign bnc_o   = bnc_q;
    assign route_o = route_q;
    assign ipm_o   = ipm_q;
    assign gen_o   = gen_q;

    a_r9_misc_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && rg_i == RG_MISC) |=> (gen_q == $past(wdata_i[0])));
endmodule

// File: rtl/rvic_pend.sv
module rvic_pend #(
    parameter int NVEC = 256,
    parameter int IW   = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NVEC-1:0] vec_i,
    input  logic            clr_we_i,
    input  logic [IW-1:0]   widx_i,
    input  logic [31:0]     wdata_i,
    output logic [NVEC-1:0] st_o,
    output logic [31:0]     rdata_o
);
    logic [NVEC-1:0] prev_q, st_q, rise, clr;

    assign rise = vec_i & ~prev_q;

    always_comb begin
        clr = '0;
        if (clr_we_i) clr[widx_i*32 +: 32] = wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prev_q <= '0;
            st_q   <= '0;
        end else begin
            prev_q <= vec_i;
            st_q   <= (st_q & ~clr) | rise;
        end
    end

    assign st_o    = st_q;
    assign rdata_o = st_q[widx_i*32 +: 32];

    a_r3_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rise) |=> ((st_q & $past(rise)) == $past(rise)));
    a_r4_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_we_i |=> ((st_q & $past(st_q)) == $past(st_q)));
endmodule

// File: rtl/rvic_steer.sv
module rvic_steer
    import rvic_pkg::*;
#(
    parameter int NVEC  = 256,
    parameter int NCORE = 4
) (
    input  logic [NVEC-1:0]        st_i,
    input  logic [NVEC-1:0]        en_i,
    input  logic [NVEC-1:0]        bnc_i,
    input  logic [NVEC*8-1:0]      route_i,
    input  logic [NVEC/4-1:0]      ipm_i,
    input  logic                   gen_i,
    input  logic [7-NCORE:0]       node_id_i,
    output logic [NCORE*LINES-1:0] irq_o
);
    localparam int NGRP = NVEC / 32;

    logic [NVEC-1:0][NCORE-1:0] hit;
    logic [NGRP-1:0][NCORE-1:0] grp;

    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        logic [7:0]       rb;
        logic [NCORE-1:0] msk, low;
        logic             live;
        assign rb     = route_i[v*8 +: 8];
        assign msk    = rb[NCORE-1:0];
        assign low    = msk & (~msk + 1'b1);
        assign live   = st_i[v] & en_i[v] & gen_i & (rb[7:NCORE] == node_id_i);
        assign hit[v] = live ? (bnc_i[v] ? low : msk) : '0;
    end

    always_comb begin
        grp = '0;
        for (int v = 0; v < NVEC; v++) grp[v/32] = grp[v/32] | hit[v];
    end

    always_comb begin
        irq_o = '0;
        for (int c = 0; c < NCORE; c++)
            for (int k = 0; k < LINES; k++)
                for (int g = 0; g < NGRP; g++)
                    irq_o[c*LINES+k] = irq_o[c*LINES+k] | (grp[g][c] & ipm_i[g*LINES+k]);
    end
endmodule

// File: rtl/rvic_top.sv
module rvic_top
    import rvic_pkg::*;
#(
    parameter int NVEC  = 256,
    parameter int NCORE = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [7-NCORE:0]       node_id_i,
    input  logic [NVEC-1:0]        vec_i,
    input  logic                   reg_we_i,
    input  logic [15:0]            reg_addr_i,
    input  logic [31:0]            reg_wdata_i,
    output logic [31:0]            reg_rdata_o,
    output logic [NCORE*LINES-1:0] irq_o
);
    localparam int          IW     = $clog2(NVEC / 4);
    localparam logic [15:0] W32_B  = 16'(NVEC / 8);
    localparam logic [15:0] GRP_B  = 16'(NVEC / 32);
    localparam logic [15:0] ROUTE_B = 16'(NVEC);

    region_e         rg;
    logic [15:0]     base, rel;
    logic [IW-1:0]   widx;
    logic [NVEC-1:0] st_w, en_w, bnc_w;
    logic [NVEC*8-1:0] route_w;
    logic [NVEC/4-1:0] ipm_w;
    logic            gen_w;
    logic [31:0]     cfg_rd, pend_rd;

    always_comb begin
        rg   = RG_NONE;
        base = '0;
        if (reg_addr_i[1:0] == 2'b00) begin
            if (reg_addr_i == OFS_MISC) begin
                rg = RG_MISC; base = OFS_MISC;
            end else if (in_rng(reg_addr_i, OFS_NODEMAP, W32_B)) begin
                rg = RG_NMAP; base = OFS_NODEMAP;
            end else if (in_rng(reg_addr_i, OFS_IPMAP, GRP_B)) begin
                rg = RG_IPMAP; base = OFS_IPMAP;
            end else if (in_rng(reg_addr_i, OFS_ENABLE, W32_B)) begin
                rg = RG_ENABLE; base = OFS_ENABLE;
            end else if (in_rng(reg_addr_i, OFS_BOUNCE, W32_B)) begin
                rg = RG_BOUNCE; base = OFS_BOUNCE;
            end else if (in_rng(reg_addr_i, OFS_STATUS, W32_B)) begin
                rg = RG_STATUS; base = OFS_STATUS;
            end else if (in_rng(reg_addr_i, OFS_ROUTE, ROUTE_B)) begin
                rg = RG_ROUTE; base = OFS_ROUTE;
            end
        end
        rel = reg_addr_i - base;
    end

    assign widx = IW'(rel >> 2);

    rvic_cfg #(.NVEC(NVEC), .IW(IW)) u_cfg (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .rg_i(rg), .widx_i(widx),
        .wdata_i(reg_wdata_i), .en_o(en_w), .bnc_o(bnc_w), .route_o(route_w),
        .ipm_o(ipm_w), .gen_o(gen_w), .rdata_o(cfg_rd)
    );

    rvic_pend #(.NVEC(NVEC), .IW(IW)) u_pend (
        .clk_i(clk_i), .rst_ni(rst_ni), .vec_i(vec_i),
        .clr_we_i(reg_we_i && rg == RG_STATUS), .widx_i(widx),
        .wdata_i(reg_wdata_i), .st_o(st_w), .rdata_o(pend_rd)
    );

    rvic_steer #(.NVEC(NVEC), .NCORE(NCORE)) u_steer (
        .st_i(st_w), .en_i(en_w), .bnc_i(bnc_w), .route_i(route_w), .ipm_i(ipm_w),
        .gen_i(gen_w), .node_id_i(node_id_i), .irq_o(irq_o)
    );

    assign reg_rdata_o = (rg == RG_STATUS) ? pend_rd : cfg_rd;

    a_r9_global_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gen_w |-> (irq_o == '0));
    a_r7_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o != '0) |-> (|(st_w & en_w)));
endmodule

// File: tb/rvic_top_tb.sv
module rvic_top_tb;
    localparam logic [3:0] NODE = 4'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  node_id = NODE;
    logic [255:0] vec = '0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] irq;
    int n_chk = 0, n_err = 0;
    logic [31:0] d;
    logic [31:0] rw;

    always #2 clk = ~clk;

    rvic_top u_dut (
        .clk_i(clk), .rst_ni(rst_n), .node_id_i(node_id), .vec_i(vec),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a; wdata = v; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic pulse(input int v);
        @(negedge clk);
        vec[v] = 1'b1;
        @(negedge clk);
        vec[v] = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", irq, 32'h0);
        rd(16'h0400, d); chk("R1 misc", d, 0);
        rd(16'h1600, d); chk("R1 enable", d, 0);
        rd(16'h1804, d); chk("R1 status", d, 0);
        rd(16'h1C40, d); chk("R1 route", d, 0);
        // R11 holes and misalignment
        rd(16'h1234, d); chk("R11 hole", d, 0);
        rd(16'h0401, d); chk("R11 misaligned", d, 0);
        // R2 readback
        wr(16'h160C, 32'hA5A5_5A5A); rd(16'h160C, d); chk("R2 enable rb", d, 32'hA5A5_5A5A);
        wr(16'h1C7C, 32'h1234_5678); rd(16'h1C7C, d); chk("R2 route rb", d, 32'h1234_5678);
        wr(16'h168C, 32'h0F0F_00FF); rd(16'h168C, d); chk("R2 bounce rb", d, 32'h0F0F_00FF);
        wr(16'h168C, 32'h0);
        // configuration
        wr(16'h0400, 32'h1);
        rd(16'h0400, d); chk("R9 misc rb", d, 32'h1);
        for (int i = 0; i < 8; i++) wr(16'h1600 + 16'(4*i), 32'hFFFF_FFFF);
        for (int w = 0; w < 2; w++) begin
            rw = '0;
            for (int b = 0; b < 4; b++) rw[8*b +: 8] = 8'(1 << (4*w+b));
            wr(16'h14C0 + 16'(4*w), rw);
        end
        rw = '0;
        for (int b = 0; b < 4; b++) rw[8*b +: 8] = {NODE, 4'(1 << b)};
        for (int w = 0; w < 64; w++) wr(16'h1C00 + 16'(4*w), rw);
        // sweep every vector: R3 R4 R6 R7
        for (int v = 0; v < 256; v++) begin
            pulse(v);
            rd(16'h1800 + 16'(4*(v/32)), d);
            chk("R3 R4 latch", d, 32'(1) << (v%32));
            chk("R6 R7 line", irq, 32'(1) << ((v%4)*8 + v/32));
            wr(16'h1800 + 16'(4*(v/32)), 32'(1) << (v%32));
            rd(16'h1800 + 16'(4*(v/32)), d);
            chk("R4 clear", d, 0);
            chk("R4 irq off", irq, 0);
        end
        // R3 held level does not re-set
        @(negedge clk); vec[10] = 1'b1;
        @(negedge clk);
        wr(16'h1800, 32'h400);
        @(negedge clk);
        rd(16'h1800, d); chk("R3 level no reset", d, 0);
        vec[10] = 1'b0;
        // R5 masked vector still latches
        wr(16'h1600, 32'hFFFF_FFF7);
        pulse(3);
        rd(16'h1800, d); chk("R5 latched masked", d, 32'h8);
        chk("R5 masked irq", irq, 0);
        wr(16'h1600, 32'hFFFF_FFFF);
        chk("R5 unmask irq", irq, 32'h0100_0000);
        wr(16'h1800, 32'h8);
        // R6 node mismatch
        wr(16'h1C04, 32'h5854_5261);
        pulse(4);
        chk("R6 other node", irq, 0);
        @(negedge clk); node_id = 4'h6;
        #1 chk("R6 node match", irq, 32'h1);
        node_id = NODE;
        wr(16'h1800, 32'h10);
        wr(16'h1C04, rw);
        // R8 single target
        wr(16'h1C08, 32'h5854_525E);
        pulse(8);
        chk("R8 multi core", irq, 32'h0101_0100);
        wr(16'h1680, 32'h100);
        rd(16'h1680, d); chk("R8 bounce rb", d, 32'h100);
        chk("R8 lowest core", irq, 32'h0000_0100);
        wr(16'h1800, 32'h100);
        wr(16'h1680, 32'h0);
        wr(16'h1C08, rw);
        // R9 global enable
        wr(16'h0400, 32'h0);
        pulse(0);
        rd(16'h1800, d); chk("R9 latched while off", d, 32'h1);
        chk("R9 irq off", irq, 0);
        rd(16'h0400, d); chk("R9 misc off rb", d, 0);
        wr(16'h0400, 32'h1);
        chk("R9 irq on", irq, 32'h1);
        wr(16'h1800, 32'h1);
        // R10 node map has no effect
        for (int i = 0; i < 8; i++) wr(16'h14A0 + 16'(4*i), 32'hDEAD_0000 | 32'(i));
        rd(16'h14B4, d); chk("R10 nodemap rb", d, 32'hDEAD_0005);
        pulse(33);
        chk("R10 irq unchanged", irq, 32'h200);
        wr(16'h1804, 32'h2);
        // R7 OR across groups and line reselect
        pulse(0); pulse(32);
        chk("R7 or", irq, 32'h3);
        wr(16'h14C0, 32'h0804_0280);
        rd(16'h14C0, d); chk("R7 ipmap rb", d, 32'h0804_0280);
        chk("R7 reselect", irq, 32'h82);
        wr(16'h1800, 32'h1); wr(16'h1804, 32'h1);
        wr(16'h14C0, 32'h0804_0201);
        chk("R7 all clear", irq, 0);
        // R12 rise wins over clear in the same cycle
        pulse(20);
        @(negedge clk);
        vec[20] = 1'b1; addr = 16'h1800; wdata = 32'h0010_0000; we = 1'b1;
        @(negedge clk);
        we = 1'b0; vec[20] = 1'b0;
        rd(16'h1800, d); chk("R12 collision", d, 32'h0010_0000);
        summary();
        $finish;
    end
endmodule